// File: doc/BRIEF.md
# General Purpose Up-Counting Timer

This block is a timer peripheral with a register window that is addressed by word. It has a counter of configurable width that counts up by one on each prescaled tick. The tick comes from one of two clock-enable inputs: a fast peripheral tick or a slow 32 kHz tick. A mode bit selects one of two counting modes. In free-run mode the counter sweeps the whole range and wraps to zero. In restart mode the counter returns to zero on the tick after it matches compare register 1.

Two sticky status flags record events. One records a compare-1 match and the other records a rollover. Software clears a flag by writing 1 to it. When hardware sets a flag in the same cycle as the clear, the set wins. An interrupt-enable register masks the flags onto one interrupt line. That line is active only while the timer is enabled. A software reset bit in the control register restores most of the registers. An enable-mode bit zeroes the counter when the timer is switched on. Compare registers 2 and 3 are storage only. The capture registers read as zero.

Register writes take effect at the clock edge. Read data is registered and appears one cycle after the index is presented. The interrupt output is also registered, so it follows a change in state by one cycle.

Top module: `gp_timer`

## Requirements
- R1: The register indices are: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2, and 9 counter. Indices 10 to 15 read as 0. `reg_rdata` shows the register addressed by `reg_idx` one clock cycle after it is presented.
- R2: Control bit fields:
  - bit 0 is enable.
  - bit 1 is enable-mode.
  - bits 5:2 are stored low-power enables.
  - bits 8:6 are the clock source.
  - bit 9 selects free-run (1) or restart (0).
  - bit 15 is software reset.
  - Bits 15:10 always read 0. All other bits read back as written.
- R3: Clock source 001 or 010 selects `tick_fast`, and 100 selects `tick_slow`. Every other code gives no ticks. The counter advances once every (prescaler+1) selected ticks. The divider restarts from zero on any control or prescaler write.
- R4: The counter holds while enable is 0 or no tick source is selected. Clearing enable freezes the count.
- R5: In free-run mode the counter wraps from all ones to 0 and sets status bit 5. The counter also sets status bit 0 when it steps onto the compare-1 value, and it keeps counting.
- R6: In restart mode the counter sets status bit 0 when it steps onto compare 1, and goes to 0 on the next step. Writing compare 1 in restart mode zeroes the counter.
- R7: Writing 1 to status bit 0 or bit 5 clears that flag. Other status bits read 0. A flag set by hardware in the same cycle as its clear stays set.
- R8: The interrupt-enable register keeps bits 5:0. `irq` is registered and equals enable AND ((status0 AND ie0) OR (status5 AND ie5)).
- R9: An enable write that turns the timer from off to on with bit 1 set zeroes the counter. Without bit 1 the count resumes from its held value.
- R10: A control write with bit 15 set is a software reset:
  - Control takes the written value with bits 15:10 and 5:0 cleared.
  - Prescaler, status, interrupt enable and counter become 0.
  - All compare registers become all ones.
- R11: After hardware reset, control, prescaler, status, interrupt enable and counter are 0, the compare registers are all ones, and `irq` is 0.
- R12: Compare 2 and compare 3 read back what was written and have no other effect. Writes to the capture registers and the counter index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Peripheral-rate clock enable |
| tick_slow | input | 1 | 32 kHz-rate clock enable |
| reg_idx | input | 4 | Register word index |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered masked interrupt |

## Verification
On every cycle, assertions check the following:
- The divider never passes its prescaler value and returns to zero after a restart.
- The counter stays still when no step, clear or software reset occurs.
- In free-run mode the counter increases by exactly one on each step. In restart mode it drops to zero after a match.
- A wrap always raises the rollover flag, and a flag stays set until a clear or software reset.
- A software reset empties the prescaler and the interrupt enable.
- `irq` never rises while the timer is disabled.

The bench scenarios are needed for the values seen at the register ports:
- the clock-source decoding, the divide ratio and the resume-versus-zero behaviour on enable;
- the field masking of the control register and the soft-reset values;
- the win of a flag set over a clear in the same cycle, which only a timed write can show.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned IE_W  = 6;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL = 4'd0,
    IDX_PRE  = 4'd1,
    IDX_STAT = 4'd2,
    IDX_IEN  = 4'd3,
    IDX_CMP1 = 4'd4,
    IDX_CMP2 = 4'd5,
    IDX_CMP3 = 4'd6,
    IDX_CAP1 = 4'd7,
    IDX_CAP2 = 4'd8,
    IDX_CNT  = 4'd9
  } reg_idx_e;

  // control field positions
  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_ENMODE = 1;
  localparam int unsigned CB_SRC_LO = 6;
  localparam int unsigned CB_FREE   = 9;
  localparam int unsigned CB_SWR    = 15;

  // status field positions
  localparam int unsigned SB_CMP  = 0;
  localparam int unsigned SB_WRAP = 5;

  localparam logic [BUS_W-1:0] CTRL_KEEP = 32'hFFFF_03FF;
  localparam logic [BUS_W-1:0] SWR_DROP  = 32'h0000_003F;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [2:0]       src,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [PRE_W-1:0] div_val,
  input  logic             restart,
  output logic             step
);
  logic             sel_tick;
  logic [PRE_W-1:0] div_q;
  logic             at_end;

  always_comb begin
    case (src)
      3'b001, 3'b010: sel_tick = tick_fast;
      3'b100:         sel_tick = tick_slow;
      default:        sel_tick = 1'b0;
    endcase
  end

  assign at_end = (div_q == div_val);
  assign step   = run && sel_tick && at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run && sel_tick) begin
      div_q <= at_end ? '0 : div_q + 1'b1;
    end
  end

  // R3: divider never exceeds the programmed ratio
  p_div_bound_r3: assert property (@(posedge clk) disable iff (rst)
    div_q <= div_val);
  // R3: a control or prescaler write restarts the divider
  p_div_restart_r3: assert property (@(posedge clk) disable iff (rst)
    restart |=> div_q == '0);
endmodule

// File: rtl/gpt_count.sv
module gpt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             clr_cnt,
  input  logic             sw_rst,
  input  logic             free_run,
  input  logic [CNT_W-1:0] cmp1,
  input  logic             w1c_cmp,
  input  logic             w1c_wrap,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_cmp,
  output logic             flag_wrap
);
  logic             adv;
  logic             restart_hit;
  logic [CNT_W-1:0] cnt_nxt;
  logic             set_cmp;
  logic             set_wrap;

  assign adv         = step && !clr_cnt && !sw_rst;
  assign restart_hit = !free_run && (cnt_q == cmp1);
  assign cnt_nxt     = restart_hit ? '0 : cnt_q + 1'b1;
  assign set_cmp     = adv && (cnt_nxt == cmp1);
  assign set_wrap    = adv && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst || sw_rst || clr_cnt) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      flag_cmp  <= 1'b0;
      flag_wrap <= 1'b0;
    end else begin
      flag_cmp  <= set_cmp  || (flag_cmp  && !w1c_cmp);
      flag_wrap <= set_wrap || (flag_wrap && !w1c_wrap);
    end
  end

  // R4: no step, no clear -> count stays put
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr_cnt && !sw_rst) |=> $stable(cnt_q));
  // R5: free-run step adds exactly one
  p_free_inc_r5: assert property (@(posedge clk) disable iff (rst)
    (step && free_run && !clr_cnt && !sw_rst) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R5: a wrap always raises the rollover flag
  p_wrap_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (step && (&cnt_q) && !clr_cnt && !sw_rst) |=> flag_wrap);
  // R6: restart mode returns to zero after a match
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !free_run && cnt_q == cmp1 && !clr_cnt && !sw_rst) |=> cnt_q == '0);
  // R7: a flag persists unless cleared or reset
  p_flag_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_cmp && !w1c_cmp && !sw_rst) |=> flag_cmp);
endmodule

// File: rtl/gp_timer.sv
module gp_timer
  import gpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic             reg_we,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  output logic             irq
);
  logic [BUS_W-1:0] ctrl_q;
  logic [PRE_W-1:0] pre_q;
  logic [IE_W-1:0]  ien_q;
  logic [CNT_W-1:0] cmp1_q, cmp2_q, cmp3_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_cmp, flag_wrap;
  logic             wr_ctrl, wr_pre, wr_stat, wr_ien, wr_cmp1, wr_cmp2, wr_cmp3;
  logic             soft_rst, en_zero, cnt_clear, div_restart, step;
  logic [BUS_W-1:0] rd_next;

  assign wr_ctrl = reg_we && (reg_idx == IDX_CTRL);
  assign wr_pre  = reg_we && (reg_idx == IDX_PRE);
  assign wr_stat = reg_we && (reg_idx == IDX_STAT);
  assign wr_ien  = reg_we && (reg_idx == IDX_IEN);
  assign wr_cmp1 = reg_we && (reg_idx == IDX_CMP1);
  assign wr_cmp2 = reg_we && (reg_idx == IDX_CMP2);
  assign wr_cmp3 = reg_we && (reg_idx == IDX_CMP3);

  assign soft_rst    = wr_ctrl && reg_wdata[CB_SWR];
  assign en_zero     = wr_ctrl && !soft_rst && reg_wdata[CB_EN] &&
                       reg_wdata[CB_ENMODE] && !ctrl_q[CB_EN];
  assign cnt_clear   = en_zero || (wr_cmp1 && !ctrl_q[CB_FREE]);
  assign div_restart = wr_ctrl || wr_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ien_q  <= '0;
      cmp1_q <= '1;
      cmp2_q <= '1;
      cmp3_q <= '1;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= soft_rst ? (reg_wdata & CTRL_KEEP & ~SWR_DROP)
                           : (reg_wdata & CTRL_KEEP);
      end
      if (soft_rst) begin
        pre_q  <= '0;
        ien_q  <= '0;
        cmp1_q <= '1;
        cmp2_q <= '1;
        cmp3_q <= '1;
      end else begin
        if (wr_pre)  pre_q  <= reg_wdata[PRE_W-1:0];
        if (wr_ien)  ien_q  <= reg_wdata[IE_W-1:0];
        if (wr_cmp1) cmp1_q <= reg_wdata[CNT_W-1:0];
        if (wr_cmp2) cmp2_q <= reg_wdata[CNT_W-1:0];
        if (wr_cmp3) cmp3_q <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  gpt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q[CB_EN]),
    .src       (ctrl_q[CB_SRC_LO +: 3]),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .div_val   (pre_q),
    .restart   (div_restart),
    .step      (step)
  );

  gpt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .clr_cnt   (cnt_clear),
    .sw_rst    (soft_rst),
    .free_run  (ctrl_q[CB_FREE]),
    .cmp1      (cmp1_q),
    .w1c_cmp   (wr_stat && reg_wdata[SB_CMP]),
    .w1c_wrap  (wr_stat && reg_wdata[SB_WRAP]),
    .cnt_q     (cnt_q),
    .flag_cmp  (flag_cmp),
    .flag_wrap (flag_wrap)
  );

  always_comb begin
    rd_next = '0;
    case (reg_idx)
      IDX_CTRL: rd_next = ctrl_q;
      IDX_PRE:  rd_next[PRE_W-1:0] = pre_q;
      IDX_STAT: begin
        rd_next[SB_CMP]  = flag_cmp;
        rd_next[SB_WRAP] = flag_wrap;
      end
      IDX_IEN:  rd_next[IE_W-1:0]  = ien_q;
      IDX_CMP1: rd_next[CNT_W-1:0] = cmp1_q;
      IDX_CMP2: rd_next[CNT_W-1:0] = cmp2_q;
      IDX_CMP3: rd_next[CNT_W-1:0] = cmp3_q;
      IDX_CNT:  rd_next[CNT_W-1:0] = cnt_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      irq       <= ctrl_q[CB_EN] &&
                   ((flag_cmp && ien_q[SB_CMP]) || (flag_wrap && ien_q[SB_WRAP]));
    end
  end

  // R8: interrupt only follows an enabled timer
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q[CB_EN]));
  // R10: software reset empties prescaler and interrupt enable
  p_swr_clears_r10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (pre_q == '0) && (ien_q == '0) && (ctrl_q[5:0] == '0));
endmodule

// File: tb/tb_gp_timer.sv
module tb_gp_timer;
  localparam int CW = 10;
  localparam logic [31:0] MASK = (32'd1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_fast = 1'b0, tick_slow = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  gp_timer #(.CNT_W(CW), .PRE_W(12)) dut (
    .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic int model_count(int steps, bit restart, int c);
    if (restart) return steps % (c + 1);
    return steps % (1 << CW);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] i, logic [31:0] d);
    @(negedge clk);
    reg_idx = i; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] i, output logic [31:0] v);
    @(negedge clk);
    reg_idx = i; reg_we = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic rdchk(string req, logic [3:0] i, logic [31:0] exp);
    logic [31:0] v;
    rd(i, v);
    chk(req, v, exp);
  endtask

  task automatic ticks(int n, bit slow);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
    end
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic irqchk(string req, logic exp);
    @(negedge clk);
    chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 / R1: reset state
    chk("R11 irq", {31'd0, irq}, 32'd0);
    rdchk("R11 ctrl", 4'd0, 32'd0);
    rdchk("R11 pre", 4'd1, 32'd0);
    rdchk("R11 stat", 4'd2, 32'd0);
    rdchk("R11 ien", 4'd3, 32'd0);
    rdchk("R11 cmp1", 4'd4, MASK);
    rdchk("R11 cmp2", 4'd5, MASK);
    rdchk("R11 cmp3", 4'd6, MASK);
    rdchk("R1 cap1", 4'd7, 32'd0);
    rdchk("R11 cnt", 4'd9, 32'd0);
    rdchk("R1 idx13", 4'd13, 32'd0);

    // R2: field masking; src 111 gives no clock (R3)
    wr(4'd0, 32'hFFFF_7FFF);
    rdchk("R2 ctrl mask", 4'd0, 32'hFFFF_03FF);
    ticks(5, 0); ticks(5, 1);
    rdchk("R3 no clock src", 4'd9, 32'd0);
    wr(4'd0, 32'd0);

    // R12: storage-only and ignored writes
    wr(4'd5, 32'h55); wr(4'd6, 32'h66);
    rdchk("R12 cmp2", 4'd5, 32'h55);
    rdchk("R12 cmp3", 4'd6, 32'h66);
    wr(4'd7, 32'h1234); wr(4'd8, 32'h4321);
    rdchk("R12 cap1", 4'd7, 32'd0);
    rdchk("R12 cap2", 4'd8, 32'd0);
    wr(4'd9, 32'h77);
    rdchk("R12 cnt write", 4'd9, 32'd0);

    // R8: ie width
    wr(4'd3, 32'hFF);
    rdchk("R8 ien mask", 4'd3, 32'h3F);
    wr(4'd3, 32'h0);

    // R3: prescaler and source selection
    wr(4'd1, 32'd2);
    wr(4'd0, 32'h243);
    ticks(9, 0);
    ticks(5, 1);
    wr(4'd0, 32'h240);
    rdchk("R3 divide by 3", 4'd9, 32'd3);
    wr(4'd0, 32'h301);
    ticks(6, 1);
    ticks(3, 0);
    rdchk("R9 resume slow", 4'd9, 32'd5);
    wr(4'd0, 32'h300);
    ticks(4, 1);
    rdchk("R4 freeze", 4'd9, 32'd5);
    wr(4'd0, 32'h303);
    rdchk("R9 zero on enable", 4'd9, 32'd0);
    wr(4'd0, 32'h300);
    wr(4'd1, 32'd0);

    // R5: free-run match and wrap
    wr(4'd0, 32'h200);
    wr(4'd4, 32'd5);
    wr(4'd2, 32'h21);
    wr(4'd0, 32'h243);
    ticks(8, 0);
    rdchk("R5 count past match", 4'd9, 32'd8);
    rdchk("R5 match flag", 4'd2, 32'h01);
    ticks(1022, 0);
    rdchk("R5 wrapped count", 4'd9, 32'd6);
    rdchk("R5 rollover flag", 4'd2, 32'h21);
    wr(4'd3, 32'h20);
    irqchk("R8 irq on rollover", 1'b1);
    wr(4'd0, 32'h242);
    irqchk("R8 irq gated by enable", 1'b0);
    wr(4'd3, 32'h0);

    // R7: clear and set-wins
    wr(4'd2, 32'hFFFF_FFFF);
    rdchk("R7 w1c", 4'd2, 32'd0);
    wr(4'd0, 32'h040);
    wr(4'd4, 32'd2);
    wr(4'd0, 32'h041);
    ticks(1, 0);
    @(negedge clk);
    reg_idx = 4'd2; reg_wdata = 32'h1; reg_we = 1'b1; tick_fast = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick_fast = 1'b0;
    rdchk("R7 set wins over clear", 4'd2, 32'h01);
    rdchk("R6 at match", 4'd9, 32'd2);
    ticks(1, 0);
    rdchk("R6 restart to zero", 4'd9, 32'd0);

    // R6: compare-1 write zeroes in restart mode
    ticks(1, 0);
    wr(4'd4, 32'd3);
    rdchk("R6 cmp1 write zeroes", 4'd9, 32'd0);
    wr(4'd2, 32'h21);
    ticks(2, 0);
    rdchk("R6 before match flag", 4'd2, 32'd0);
    ticks(1, 0);
    rdchk("R6 match flag", 4'd2, 32'h01);
    ticks(6, 0);
    rdchk("R6 period", 4'd9, 32'd1);
    wr(4'd3, 32'h01);
    irqchk("R8 irq on match", 1'b1);
    wr(4'd0, 32'h040);
    irqchk("R8 irq off when disabled", 1'b0);

    // R10: software reset
    wr(4'd1, 32'd5); wr(4'd3, 32'h21); wr(4'd5, 32'd9);
    wr(4'd0, 32'h827F);
    rdchk("R10 ctrl", 4'd0, 32'h240);
    rdchk("R10 pre", 4'd1, 32'd0);
    rdchk("R10 stat", 4'd2, 32'd0);
    rdchk("R10 ien", 4'd3, 32'd0);
    rdchk("R10 cmp1", 4'd4, MASK);
    rdchk("R10 cmp2", 4'd5, MASK);
    rdchk("R10 cnt", 4'd9, 32'd0);

    // random: R3/R6 count model
    for (int it = 0; it < 20; it++) begin
      int pr, n, ones, c;
      bit rs;
      pr = $urandom % 4;
      rs = $urandom % 2;
      c  = 5 + ($urandom % 20);
      n  = 20 + ($urandom % 40);
      ones = 0;
      wr(4'd0, rs ? 32'h040 : 32'h240);
      wr(4'd1, pr);
      wr(4'd4, c);
      wr(4'd0, rs ? 32'h043 : 32'h243);
      for (int k = 0; k < n; k++) begin
        @(negedge clk);
        tick_fast = $urandom % 2;
        if (tick_fast) ones++;
      end
      @(negedge clk);
      tick_fast = 1'b0;
      wr(4'd0, rs ? 32'h040 : 32'h240);
      rdchk(rs ? "R6 random restart" : "R3 random divide", 4'd9,
            model_count(ones / (pr + 1), rs, c));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule